// File: doc/BRIEF.md
# Encoded Interrupt Level Holding Unit

This block sits between two groups of four external interrupt pins and a CPU's interrupt input. Each group normally carries a 4-bit active-low code that names an interrupt level from 1 to 15. The block synchronizes both groups, filters out codes that do not hold steady, and picks the stronger of the two requests. It then presents a 4-bit request level and a pending flag to the CPU.

Two behaviours can be chosen. In hold mode the strongest level seen is kept until the CPU accepts an interrupt, or until software writes a clear strobe for the group it came from. It is kept even if the pins withdraw the request or fall to a weaker code. In follow mode nothing is kept, and the output tracks the filtered pins. The block also owns the CPU's 4-bit mask level. On acceptance it can copy the accepted level into that mask level. A separate per-level block vector stops delivery of chosen levels. Either group can instead be switched to four independent active-high IRQ lines.

Top module: `irl_hold_unit`

## Requirements
- R1: Each group's pin code is active-low: code 4'b1111 means no request, and any other code requests level = bitwise inverse of the code (1..15). In follow mode (`follow_mode`=1) `req_level` shows the higher of the two groups' levels, and 0 when neither requests.
- R2: A code reaches the decoder only after two synchronizer flops, and only once two consecutive synchronized samples agree. A code that is present for a single clock cycle is never detected.
- R3: When both groups request the same level, the request is attributed to the group on pins 3..0. A later `clr_b` does not release it, and a later `clr_a` does.
- R4: In hold mode (`follow_mode`=0) a detected level stays on `req_level` after the pins withdraw the request or drop to a lower level.
- R5: In hold mode a newly detected level strictly above the held level replaces it.
- R6: A one-cycle `cpu_ack` in hold mode releases the held level: `req_level` reads 0 in the cycle after the ack edge. If the pins still request, the level is taken again one cycle later.
- R7: `clr_a` releases a held level only if it came from pins 3..0, and `clr_b` only if it came from pins 7..4.
- R8: Setting bit L of `lvl_block` forces `req_pending` to 0 while `req_level` is L. It does not release the held level, and clearing the bit makes the request pending again.
- R9: In follow mode no level is kept: when the pins drop to a lower code or withdraw, `req_level` follows.
- R10: `req_pending` is 1 only when `req_level` is non-zero, strictly greater than `mask_level`, and not blocked.
- R11: `mask_wr` loads `mask_level` from `mask_wdata`. On `cpu_ack` with `req_pending` = 1 and `auto_mask` = 1, `mask_level` takes the accepted `req_level`. With `auto_mask` = 0 an ack leaves `mask_level` unchanged.
- R12: With `irq_sel_a` (or `irq_sel_b`) set to 1, that group is excluded from level selection. Its synchronized pins appear inverted (active-high) on `irq_a` (or `irq_b`).
- R13: After reset, `req_level`, `req_pending`, `mask_level`, `irq_a` and `irq_b` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_a | input | 4 | Pin group on pins 3..0, active-low code |
| pins_b | input | 4 | Pin group on pins 7..4, active-low code |
| follow_mode | input | 1 | 1: output follows pins; 0: hold mode |
| irq_sel_a | input | 1 | Group A used as four independent IRQ lines |
| irq_sel_b | input | 1 | Group B used as four independent IRQ lines |
| auto_mask | input | 1 | Load mask level with accepted level on ack |
| cpu_ack | input | 1 | CPU accepts an interrupt (one-cycle pulse) |
| clr_a | input | 1 | Release strobe for a held level from group A |
| clr_b | input | 1 | Release strobe for a held level from group B |
| lvl_block | input | 16 | Per-level delivery block, bit L blocks level L |
| mask_wr | input | 1 | Write strobe for the mask level |
| mask_wdata | input | 4 | Data for the mask level write |
| req_level | output | 4 | Request level presented to the CPU |
| req_pending | output | 1 | Request pending to the CPU |
| mask_level | output | 4 | CPU interrupt mask level |
| irq_a | output | 4 | Independent IRQ lines from group A, active-high |
| irq_b | output | 4 | Independent IRQ lines from group B, active-high |

## Verification
A pin change driven before clock edge k reaches the first synchronizer at k and the second at k+1. It is confirmed against the previous sample at k+3. It is visible on `req_level` right after k+3 in follow mode, and after k+4 in hold mode, when it passes through the hold register. The bench therefore waits six cycles after every pin change before sampling, and samples on the falling edge. Strobes (`cpu_ack`, `clr_a`, `clr_b`, `mask_wr`) act on the rising edge they span, and their result is checked at the next falling edge. The re-take after an ack is checked one cycle later. The IRQ lines leave the second synchronizer and are checked after the same settle time.

// File: rtl/irl_pkg.sv
package irl_pkg;
    localparam int LVL_W  = 4;
    localparam int N_LVL  = 1 << LVL_W;
    localparam int N_GRP  = 2;

    typedef logic [LVL_W-1:0] lvl_t;

    // source of a held request: 0 = group on pins 3..0, 1 = group on pins 7..4
    typedef struct packed {
        lvl_t s1;
        lvl_t s2;
        lvl_t prev;
        lvl_t det;
    } filt_t;

    typedef struct packed {
        lvl_t held_lvl;
        logic held_src;
        lvl_t mask_lvl;
    } hold_t;
endpackage

// File: rtl/irl_pin_filter.sv
module irl_pin_filter
    import irl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  lvl_t pins,
    output lvl_t sync_pins,
    output lvl_t det_lvl
);
    filt_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pins;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        if (st_q.s2 == st_q.prev)
            st_d.det = ~st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1   <= '1;
            st_q.s2   <= '1;
            st_q.prev <= '1;
            st_q.det  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_pins = st_q.s2;
    assign det_lvl   = st_q.det;

    // R2: the detected level only moves after two agreeing synchronized samples
    a_r2_two_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s2 != st_q.prev) |=> $stable(st_q.det));
endmodule

// File: rtl/irl_pick.sv
module irl_pick
    import irl_pkg::*;
(
    input  lvl_t lvl_a,
    input  lvl_t lvl_b,
    input  logic use_a,
    input  logic use_b,
    output lvl_t win_lvl,
    output logic win_src
);
    lvl_t eff_a, eff_b;

    always_comb begin
        eff_a = use_a ? lvl_a : '0;
        eff_b = use_b ? lvl_b : '0;
        // ties go to group A
        if (eff_a >= eff_b) begin
            win_lvl = eff_a;
            win_src = 1'b0;
        end else begin
            win_lvl = eff_b;
            win_src = 1'b1;
        end
    end
endmodule

// File: rtl/irl_hold_core.sv
module irl_hold_core
    import irl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  lvl_t             cand_lvl,
    input  logic             cand_src,
    input  logic             follow_mode,
    input  logic             auto_mask,
    input  logic             cpu_ack,
    input  logic             clr_a,
    input  logic             clr_b,
    input  logic [N_LVL-1:0] lvl_block,
    input  logic             mask_wr,
    input  lvl_t             mask_wdata,
    output lvl_t             out_lvl,
    output logic             out_pend,
    output lvl_t             mask_lvl
);
    hold_t st_d, st_q;
    logic  rel_grp;

    always_comb begin
        out_lvl  = follow_mode ? cand_lvl : st_q.held_lvl;
        out_pend = (out_lvl != '0) && (out_lvl > st_q.mask_lvl) && !lvl_block[out_lvl];
        rel_grp  = (clr_a && !st_q.held_src) || (clr_b && st_q.held_src);

        st_d = st_q;
        if (follow_mode || cpu_ack || rel_grp) begin
            st_d.held_lvl = '0;
            st_d.held_src = 1'b0;
        end else if (cand_lvl > st_q.held_lvl) begin
            st_d.held_lvl = cand_lvl;
            st_d.held_src = cand_src;
        end

        if (mask_wr)
            st_d.mask_lvl = mask_wdata;
        else if (cpu_ack && out_pend && auto_mask)
            st_d.mask_lvl = out_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign mask_lvl = st_q.mask_lvl;

    // R4: without ack or release, the held level never decreases in hold mode
    a_r4_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!follow_mode && !cpu_ack && !clr_a && !clr_b)
        |=> (follow_mode || st_q.held_lvl >= $past(st_q.held_lvl)));

    // R6: an ack empties the hold register
    a_r6_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> (st_q.held_lvl == '0));

    // R11: automatic mask update takes the accepted level
    a_r11_auto_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && out_pend && auto_mask && !mask_wr) |=> (mask_lvl == $past(out_lvl)));

    // R11: with automatic update off and no write, the mask level is kept
    a_r11_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_mask && !mask_wr) |=> $stable(mask_lvl));

    // R9: follow mode keeps nothing
    a_r9_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        follow_mode |=> (st_q.held_lvl == '0));

    // R10: a pending request is above the mask level
    a_r10_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
        out_pend |-> (out_lvl > mask_lvl));
endmodule

// File: rtl/irl_hold_unit.sv
module irl_hold_unit
    import irl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  pins_a,
    input  logic [3:0]  pins_b,
    input  logic        follow_mode,
    input  logic        irq_sel_a,
    input  logic        irq_sel_b,
    input  logic        auto_mask,
    input  logic        cpu_ack,
    input  logic        clr_a,
    input  logic        clr_b,
    input  logic [15:0] lvl_block,
    input  logic        mask_wr,
    input  logic [3:0]  mask_wdata,
    output logic [3:0]  req_level,
    output logic        req_pending,
    output logic [3:0]  mask_level,
    output logic [3:0]  irq_a,
    output logic [3:0]  irq_b
);
    lvl_t grp_pins [N_GRP];
    lvl_t grp_sync [N_GRP];
    lvl_t grp_det  [N_GRP];
    logic grp_irq  [N_GRP];
    lvl_t cand_lvl;
    logic cand_src;

    assign grp_pins[0] = pins_a;
    assign grp_pins[1] = pins_b;
    assign grp_irq[0]  = irq_sel_a;
    assign grp_irq[1]  = irq_sel_b;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        irl_pin_filter u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .pins      (grp_pins[g]),
            .sync_pins (grp_sync[g]),
            .det_lvl   (grp_det[g])
        );
    end

    assign irq_a = irq_sel_a ? ~grp_sync[0] : '0;
    assign irq_b = irq_sel_b ? ~grp_sync[1] : '0;

    irl_pick u_pick (
        .lvl_a   (grp_det[0]),
        .lvl_b   (grp_det[1]),
        .use_a   (!grp_irq[0]),
        .use_b   (!grp_irq[1]),
        .win_lvl (cand_lvl),
        .win_src (cand_src)
    );

    irl_hold_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .cand_lvl    (cand_lvl),
        .cand_src    (cand_src),
        .follow_mode (follow_mode),
        .auto_mask   (auto_mask),
        .cpu_ack     (cpu_ack),
        .clr_a       (clr_a),
        .clr_b       (clr_b),
        .lvl_block   (lvl_block),
        .mask_wr     (mask_wr),
        .mask_wdata  (mask_wdata),
        .out_lvl     (req_level),
        .out_pend    (req_pending),
        .mask_lvl    (mask_level)
    );

    // R12: IRQ lines stay low for a group in encoded-level use
    a_r12_lines_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_sel_a |-> irq_a == '0) and (!irq_sel_b |-> irq_b == '0));
endmodule

// File: tb/irl_hold_unit_test.sv
module irl_hold_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pins_a = 4'hF, pins_b = 4'hF;
    logic        follow_mode = 1'b0, irq_sel_a = 1'b0, irq_sel_b = 1'b0;
    logic        auto_mask = 1'b0, cpu_ack = 1'b0, clr_a = 1'b0, clr_b = 1'b0;
    logic [15:0] lvl_block = '0;
    logic        mask_wr = 1'b0;
    logic [3:0]  mask_wdata = '0;
    logic [3:0]  req_level, mask_level, irq_a, irq_b;
    logic        req_pending;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irl_hold_unit uut (
        .clk(clk), .rst_n(rst_n), .pins_a(pins_a), .pins_b(pins_b),
        .follow_mode(follow_mode), .irq_sel_a(irq_sel_a), .irq_sel_b(irq_sel_b),
        .auto_mask(auto_mask), .cpu_ack(cpu_ack), .clr_a(clr_a), .clr_b(clr_b),
        .lvl_block(lvl_block), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .req_level(req_level), .req_pending(req_pending), .mask_level(mask_level),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    // {pins_a, pins_b, expected level}, follow mode, mask 0
    localparam logic [11:0] VEC [10] = '{
        {4'hF, 4'hF, 4'd0},   // R1 idle
        {4'hE, 4'hF, 4'd1},   // R1 lowest level
        {4'hF, 4'h0, 4'd15},  // R1 highest from B
        {4'hA, 4'hC, 4'd5},   // R1 A above B
        {4'hC, 4'hA, 4'd5},   // R1 B above A
        {4'h6, 4'hF, 4'd9},   // R1
        {4'h0, 4'hF, 4'd15},  // R9
        {4'h8, 4'hF, 4'd7},   // R9 lower level follows
        {4'hB, 4'hB, 4'd4},   // R1 tie
        {4'hF, 4'hF, 4'd0}    // R9 withdraw follows
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk) s = 1'b1;
        @(negedge clk) s = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 level", req_level, 0);
        chk("R13 pending", req_pending, 0);
        chk("R13 mask", mask_level, 0);
        chk("R13 irq", {irq_a, irq_b}, 0);
        rst_n = 1'b1;

        follow_mode = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            pins_a = VEC[i][11:8];
            pins_b = VEC[i][7:4];
            settle();
            chk($sformatf("R1/R9 vec%0d level", i), req_level, VEC[i][3:0]);
            chk($sformatf("R10 vec%0d pending", i), req_pending, VEC[i][3:0] != 0);
        end

        // hold mode
        follow_mode = 1'b0;
        settle();
        pins_a = 4'hC; settle();
        chk("R4 taken", req_level, 3);
        pins_a = 4'hF; settle();
        chk("R4 kept after withdraw", req_level, 3);
        pins_a = 4'hD; settle();
        chk("R4 kept over lower", req_level, 3);
        pins_a = 4'h8; settle();
        chk("R5 higher replaces", req_level, 7);
        pins_a = 4'hF; settle();
        pulse(clr_b);
        chk("R7 clr_b ignores A", req_level, 7);
        pulse(clr_a);
        chk("R7 clr_a releases", req_level, 0);

        pins_b = 4'h9; settle();
        chk("R7 B taken", req_level, 6);
        pins_b = 4'hF; settle();
        pulse(clr_a);
        chk("R7 clr_a ignores B", req_level, 6);
        pulse(cpu_ack);
        chk("R6 ack releases", req_level, 0);

        pins_a = 4'hA; pins_b = 4'hA; settle();
        chk("R3 tie level", req_level, 5);
        pins_a = 4'hF; pins_b = 4'hF; settle();
        pulse(clr_b);
        chk("R3 tie owned by A", req_level, 5);
        pulse(clr_a);
        chk("R3 released by clr_a", req_level, 0);

        pins_a = 4'hB; settle();
        pulse(cpu_ack);
        chk("R6 empty after ack", req_level, 0);
        @(negedge clk);
        chk("R6 retaken", req_level, 4);
        pins_a = 4'hF; settle();
        pulse(cpu_ack);

        // R2 one-cycle glitch
        @(negedge clk) pins_a = 4'hC;
        @(negedge clk) pins_a = 4'hF;
        settle();
        chk("R2 glitch ignored", req_level, 0);

        // R8 block vector
        lvl_block[9] = 1'b1;
        pins_a = 4'h6; settle();
        chk("R8 level shown", req_level, 9);
        chk("R8 blocked", req_pending, 0);
        pins_a = 4'hF; settle();
        lvl_block[9] = 1'b0;
        @(negedge clk);
        chk("R8 still held", req_level, 9);
        chk("R8 pending after unblock", req_pending, 1);
        pulse(cpu_ack);

        // R10 / R11 mask level
        pins_a = 4'h6; settle();
        auto_mask = 1'b1;
        pulse(cpu_ack);
        chk("R11 auto load", mask_level, 9);
        @(negedge clk);
        chk("R10 equal not pending", req_pending, 0);
        chk("R10 level retaken", req_level, 9);
        mask_wdata = 4'd3;
        pulse(mask_wr);
        chk("R11 write", mask_level, 3);
        chk("R10 above mask pending", req_pending, 1);
        auto_mask = 1'b0;
        pulse(cpu_ack);
        chk("R11 no auto keeps mask", mask_level, 3);
        pins_a = 4'hF; settle();
        pulse(cpu_ack);
        mask_wdata = 4'd0;
        pulse(mask_wr);

        // R12 independent IRQ lines
        follow_mode = 1'b1;
        irq_sel_a = 1'b1;
        pins_a = 4'h5; settle();
        chk("R12 lines A", irq_a, 4'hA);
        chk("R12 A excluded", req_level, 0);
        irq_sel_b = 1'b1;
        pins_b = 4'h3; settle();
        chk("R12 lines B", irq_b, 4'hC);
        chk("R12 B excluded", req_level, 0);
        irq_sel_b = 1'b0;
        settle();
        chk("R12 B encoded again", req_level, 12);
        chk("R12 B lines quiet", irq_b, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule